// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multicycle processor. Its state is a microaddress register, and that register selects one word of a built-in, read-only control store. The word drives every datapath control field for the current cycle: the ALU operation, the two ALU operand selects, the register-file action, the memory action and the PC write mode. A sequencing field in the same word picks the next microaddress. The choices are to step to the following word, to jump through one of two opcode-indexed dispatch tables, or to go back to the fetch word.

The datapath, memories and register file sit outside the block. The only input that the sequencer itself takes from them is the opcode of the instruction currently held. The control store layout is fixed: fetch at 0, decode at 1, memory address at 2, load read at 3, load write-back at 4, store at 5, R-type at 6 and 7, branch at 8 and jump at 9. Every other address holds an empty word that goes back to fetch. If an opcode has no entry in the dispatch table being used, the sequencer returns to fetch and raises an illegal-opcode flag.

Top module: `mseq_ctrl`

Field encodings used below: ALU op 0 add, 1 subtract, 2 function-coded. SRC1 0 PC, 1 register A. SRC2 0 register B, 1 constant four, 2 sign-extended immediate, 3 sign-extended immediate shifted. Register action 0 idle, 1 read, 2 write ALU result, 3 write memory data. Memory action 0 idle, 1 read at PC, 2 read at ALU result, 3 write at ALU result. PC action 0 hold, 1 write ALU result, 2 conditional on ALU zero, 3 jump target. Opcodes: R-type 0x00, jump 0x02, branch 0x04, load 0x23, store 0x2B.

## Requirements
- R1: An asserted (low) asynchronous reset forces the microaddress to 0 at once, and the outputs then show the fetch word.
- R2: At microaddress 0 the outputs are ALU op 0, SRC1 0, SRC2 1, register 0, memory 1, PC 1, and the next microaddress is 1.
- R3: At microaddress 1 the outputs are ALU op 0, SRC1 0, SRC2 3, register 1, memory 0, PC 0. The next address comes from dispatch table 1: opcodes 0x23 and 0x2B go to 2, 0x00 goes to 6, 0x04 goes to 8 and 0x02 goes to 9.
- R4: At microaddress 2 the outputs are ALU op 0, SRC1 1, SRC2 2, register 0, memory 0, PC 0. The next address comes from dispatch table 2: opcode 0x23 goes to 3 and 0x2B goes to 5.
- R5: Load path: microaddress 3 drives memory 2 and steps to 4. Microaddress 4 drives register 3 and returns to 0.
- R6: Store path: microaddress 5 drives memory 3 and returns to 0.
- R7: R-type path: microaddress 6 drives ALU op 2, SRC1 1, SRC2 0 and steps to 7. Microaddress 7 drives register 2 and returns to 0.
- R8: Branch path: microaddress 8 drives ALU op 1, SRC1 1, SRC2 0, PC 2 and returns to 0.
- R9: Jump path: microaddress 9 drives PC 3 and returns to 0.
- R10: If the opcode has no entry in the table used at address 1 or at address 2, illegal_op is 1 during that cycle, the next microaddress is 0, and illegal_op is 0 in every other cycle.
- R11: A change of opcode while the microaddress is not 1 or 2 changes neither the outputs nor the next microaddress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode of the current instruction |
| alu_op | output | 2 | ALU operation field |
| src1_sel | output | 1 | ALU first operand select |
| src2_sel | output | 2 | ALU second operand select |
| reg_act | output | 2 | Register-file action |
| mem_act | output | 2 | Memory action |
| pc_act | output | 2 | PC write mode |
| upc | output | 4 | Current microaddress |
| illegal_op | output | 1 | Opcode had no dispatch entry this cycle |

## Verification
All control fields are read combinationally from the word at the current microaddress. A corrupted microaddress therefore shows on upc and on at least one control field in the same cycle. A wrong dispatch or sequencing choice shows one clock edge later, as an unexpected upc and control word in the next cycle. For that reason every instruction class is stepped through one cycle at a time and the full output vector is compared each cycle. Opcodes are also changed in cycles where the opcode must be ignored, so that a sequencer that reads it at the wrong time sends the trace down the wrong path.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNC = 2'd2, ALU_PASS = 2'd3} alu_e;
  typedef enum logic       {S1_PC = 1'b0, S1_REGA = 1'b1} src1_e;
  typedef enum logic [1:0] {S2_REGB = 2'd0, S2_FOUR = 2'd1, S2_IMM = 2'd2, S2_IMMSH = 2'd3} src2_e;
  typedef enum logic [1:0] {RG_IDLE = 2'd0, RG_READ = 2'd1, RG_WR_ALU = 2'd2, RG_WR_MDR = 2'd3} reg_e;
  typedef enum logic [1:0] {MM_IDLE = 2'd0, MM_RD_PC = 2'd1, MM_RD_ALU = 2'd2, MM_WR_ALU = 2'd3} mem_e;
  typedef enum logic [1:0] {PC_HOLD = 2'd0, PC_ALU = 2'd1, PC_COND = 2'd2, PC_JUMP = 2'd3} pc_e;
  typedef enum logic [1:0] {SQ_NEXT = 2'd0, SQ_DISP1 = 2'd1, SQ_DISP2 = 2'd2, SQ_FETCH = 2'd3} seq_e;

  typedef struct packed {
    alu_e  alu;
    src1_e s1;
    src2_e s2;
    reg_e  rg;
    mem_e  mm;
    pc_e   pc;
    seq_e  sq;
  } uword_t;

  // Microaddress map; dispatch targets depend on these positions.
  localparam int unsigned UA_FETCH  = 0;
  localparam int unsigned UA_DECODE = 1;
  localparam int unsigned UA_MADDR  = 2;
  localparam int unsigned UA_LDRD   = 3;
  localparam int unsigned UA_LDWB   = 4;
  localparam int unsigned UA_ST     = 5;
  localparam int unsigned UA_REXE   = 6;
  localparam int unsigned UA_RWB    = 7;
  localparam int unsigned UA_BR     = 8;
  localparam int unsigned UA_JMP    = 9;
  localparam int unsigned UA_USED   = 10;

  // Opcode values used by the dispatch tables.
  localparam int unsigned OPV_RTYPE = 'h00;
  localparam int unsigned OPV_JUMP  = 'h02;
  localparam int unsigned OPV_BR    = 'h04;
  localparam int unsigned OPV_LOAD  = 'h23;
  localparam int unsigned OPV_STORE = 'h2B;

  function automatic uword_t mk_word(alu_e a, src1_e s1, src2_e s2, reg_e r,
                                     mem_e m, pc_e p, seq_e q);
    uword_t w;
    w.alu = a;
    w.s1  = s1;
    w.s2  = s2;
    w.rg  = r;
    w.mm  = m;
    w.pc  = p;
    w.sq  = q;
    return w;
  endfunction

  // Control store contents, computed per address.
  function automatic uword_t uword_at(int unsigned a);
    uword_t w;
    case (a)
      UA_FETCH:  w = mk_word(ALU_ADD,  S1_PC,   S2_FOUR,  RG_IDLE,   MM_RD_PC,  PC_ALU,  SQ_NEXT);
      UA_DECODE: w = mk_word(ALU_ADD,  S1_PC,   S2_IMMSH, RG_READ,   MM_IDLE,   PC_HOLD, SQ_DISP1);
      UA_MADDR:  w = mk_word(ALU_ADD,  S1_REGA, S2_IMM,   RG_IDLE,   MM_IDLE,   PC_HOLD, SQ_DISP2);
      UA_LDRD:   w = mk_word(ALU_ADD,  S1_PC,   S2_REGB,  RG_IDLE,   MM_RD_ALU, PC_HOLD, SQ_NEXT);
      UA_LDWB:   w = mk_word(ALU_ADD,  S1_PC,   S2_REGB,  RG_WR_MDR, MM_IDLE,   PC_HOLD, SQ_FETCH);
      UA_ST:     w = mk_word(ALU_ADD,  S1_PC,   S2_REGB,  RG_IDLE,   MM_WR_ALU, PC_HOLD, SQ_FETCH);
      UA_REXE:   w = mk_word(ALU_FUNC, S1_REGA, S2_REGB,  RG_IDLE,   MM_IDLE,   PC_HOLD, SQ_NEXT);
      UA_RWB:    w = mk_word(ALU_ADD,  S1_PC,   S2_REGB,  RG_WR_ALU, MM_IDLE,   PC_HOLD, SQ_FETCH);
      UA_BR:     w = mk_word(ALU_SUB,  S1_REGA, S2_REGB,  RG_IDLE,   MM_IDLE,   PC_COND, SQ_FETCH);
      UA_JMP:    w = mk_word(ALU_ADD,  S1_PC,   S2_REGB,  RG_IDLE,   MM_IDLE,   PC_JUMP, SQ_FETCH);
      default:   w = mk_word(ALU_ADD,  S1_PC,   S2_REGB,  RG_IDLE,   MM_IDLE,   PC_HOLD, SQ_FETCH);
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mseq_store.sv
module mseq_store
  import mseq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  localparam int DEPTH = 2 ** AW;

  uword_t rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_rom
    assign rom[a] = uword_at(a);
  end

  assign word = rom[addr];

  initial begin
    assert (DEPTH >= UA_USED) else $error("control store too small for its map");
  end
endmodule

// File: rtl/mseq_dispatch.sv
module mseq_dispatch #(
  parameter int AW  = 4,
  parameter int OPW = 6
) (
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  t1_addr,
  output logic           t1_hit,
  output logic [AW-1:0]  t2_addr,
  output logic           t2_hit
);
  import mseq_pkg::*;

  localparam logic [OPW-1:0] OP_R  = OPW'(OPV_RTYPE);
  localparam logic [OPW-1:0] OP_J  = OPW'(OPV_JUMP);
  localparam logic [OPW-1:0] OP_B  = OPW'(OPV_BR);
  localparam logic [OPW-1:0] OP_LD = OPW'(OPV_LOAD);
  localparam logic [OPW-1:0] OP_ST = OPW'(OPV_STORE);

  // Table 1: class entry point, {hit, address}.
  function automatic logic [AW:0] table1(logic [OPW-1:0] op);
    case (op)
      OP_LD, OP_ST: return {1'b1, AW'(UA_MADDR)};
      OP_R:         return {1'b1, AW'(UA_REXE)};
      OP_B:         return {1'b1, AW'(UA_BR)};
      OP_J:         return {1'b1, AW'(UA_JMP)};
      default:      return {1'b0, AW'(UA_FETCH)};
    endcase
  endfunction

  // Table 2: load or store path, {hit, address}.
  function automatic logic [AW:0] table2(logic [OPW-1:0] op);
    case (op)
      OP_LD:   return {1'b1, AW'(UA_LDRD)};
      OP_ST:   return {1'b1, AW'(UA_ST)};
      default: return {1'b0, AW'(UA_FETCH)};
    endcase
  endfunction

  assign {t1_hit, t1_addr} = table1(opcode);
  assign {t2_hit, t2_addr} = table2(opcode);
endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_e          seq,
  input  logic [AW-1:0] t1_addr,
  input  logic          t1_hit,
  input  logic [AW-1:0] t2_addr,
  input  logic          t2_hit,
  output logic [AW-1:0] upc,
  output logic          miss
);
  logic [AW-1:0] upc_nx;
  logic          is_disp;

  assign is_disp = (seq == SQ_DISP1) || (seq == SQ_DISP2);

  always_comb begin
    miss   = 1'b0;
    upc_nx = AW'(UA_FETCH);
    case (seq)
      SQ_NEXT:  upc_nx = upc + AW'(1);
      SQ_DISP1: begin
        miss   = !t1_hit;
        upc_nx = t1_hit ? t1_addr : AW'(UA_FETCH);
      end
      SQ_DISP2: begin
        miss   = !t2_hit;
        upc_nx = t2_hit ? t2_addr : AW'(UA_FETCH);
      end
      default:  upc_nx = AW'(UA_FETCH);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= AW'(UA_FETCH);
    else        upc <= upc_nx;
  end

  // R2, R5, R7: step field advances by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SQ_NEXT) |=> (upc == $past(upc) + AW'(1)));

  // R6, R8, R9: return field goes to fetch
  a_r9_return: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SQ_FETCH) |=> (upc == AW'(UA_FETCH)));

  // R10: a miss only in a dispatch cycle, and it lands on fetch
  a_r10_miss_disp: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> is_disp);
  a_r10_miss_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (upc == AW'(UA_FETCH)));

  // R3: a table 1 hit follows the table
  a_r3_disp1: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SQ_DISP1 && t1_hit) |=> (upc == $past(t1_addr)));

  // R4: table 2 only reaches the load or store entry
  a_r4_disp2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SQ_DISP2 && t2_hit) |=> (upc == AW'(UA_LDRD) || upc == AW'(UA_ST)));
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int AW  = 4,
  parameter int OPW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  output logic [1:0]     alu_op,
  output logic           src1_sel,
  output logic [1:0]     src2_sel,
  output logic [1:0]     reg_act,
  output logic [1:0]     mem_act,
  output logic [1:0]     pc_act,
  output logic [AW-1:0]  upc,
  output logic           illegal_op
);
  uword_t        word;
  logic [AW-1:0] t1_addr, t2_addr;
  logic          t1_hit, t2_hit;

  mseq_store #(.AW(AW)) u_store (
    .addr (upc),
    .word (word)
  );

  mseq_dispatch #(.AW(AW), .OPW(OPW)) u_disp (
    .opcode  (opcode),
    .t1_addr (t1_addr),
    .t1_hit  (t1_hit),
    .t2_addr (t2_addr),
    .t2_hit  (t2_hit)
  );

  mseq_next #(.AW(AW)) u_next (
    .clk     (clk),
    .rst_n   (rst_n),
    .seq     (word.sq),
    .t1_addr (t1_addr),
    .t1_hit  (t1_hit),
    .t2_addr (t2_addr),
    .t2_hit  (t2_hit),
    .upc     (upc),
    .miss    (illegal_op)
  );

  assign alu_op   = word.alu;
  assign src1_sel = word.s1;
  assign src2_sel = word.s2;
  assign reg_act  = word.rg;
  assign mem_act  = word.mm;
  assign pc_act   = word.pc;

  // R1: first cycle after reset is the fetch word
  a_r1_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (upc == AW'(UA_FETCH)));

  // R2: the fetch address reads memory at PC and writes PC
  a_r2_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == AW'(UA_FETCH)) |-> (mem_act == 2'd1 && pc_act == 2'd1 && !illegal_op));

  // R10: illegal flag never holds two cycles
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> !illegal_op);
endmodule

// File: tb/tb_mseq_ctrl.sv
`timescale 1ns/1ps
module tb_mseq_ctrl;
  localparam int AW  = 4;
  localparam int OPW = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [OPW-1:0] opcode = '0;
  logic [1:0]     alu_op, src2_sel, reg_act, mem_act, pc_act;
  logic           src1_sel, illegal_op;
  logic [AW-1:0]  upc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mseq_ctrl #(.AW(AW), .OPW(OPW)) dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .alu_op(alu_op), .src1_sel(src1_sel), .src2_sel(src2_sel),
    .reg_act(reg_act), .mem_act(mem_act), .pc_act(pc_act),
    .upc(upc), .illegal_op(illegal_op)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Compares {upc, alu, src1, src2, reg, mem, pc, illegal}.
  task automatic expect_out(string req, int ea, int ealu, int es1, int es2,
                            int erg, int emm, int epc, int eill);
    logic [AW+12-1:0] act, exp;
    act = {upc, alu_op, src1_sel, src2_sel, reg_act, mem_act, pc_act, illegal_op};
    exp = {AW'(ea), 2'(ealu), 1'(es1), 2'(es2), 2'(erg), 2'(emm), 2'(epc), 1'(eill)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic exp_fetch(string req);  expect_out(req, 0, 0, 0, 1, 0, 1, 1, 0); endtask
  task automatic exp_decode(string req, int ill); expect_out(req, 1, 0, 0, 3, 1, 0, 0, ill); endtask
  task automatic exp_maddr(string req, int ill);  expect_out(req, 2, 0, 1, 2, 0, 0, 0, ill); endtask

  task automatic t_reset();
    exp_fetch("R1 reset state");
    tick();
    exp_decode("R2 fetch steps to 1", 0);
    tick();
    rst_n = 1'b0;
    #1;
    exp_fetch("R1 async reset mid-instruction");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_load();
    opcode = 6'h23;
    exp_fetch("R2 fetch word");
    tick(); exp_decode("R3 decode load", 0);
    tick(); exp_maddr("R4 mem address load", 0);
    tick();
    opcode = 6'h02;
    expect_out("R5 load read", 3, 0, 0, 0, 0, 2, 0, 0);
    tick();
    expect_out("R11 load write-back despite opcode change", 4, 0, 0, 0, 3, 0, 0, 0);
    tick(); exp_fetch("R5 load returns to fetch");
  endtask

  task automatic t_store();
    opcode = 6'h2B;
    tick(); exp_decode("R3 decode store", 0);
    tick(); exp_maddr("R4 mem address store", 0);
    tick(); expect_out("R6 store write", 5, 0, 0, 0, 0, 3, 0, 0);
    tick(); exp_fetch("R6 store returns to fetch");
  endtask

  task automatic t_rtype();
    opcode = 6'h00;
    tick(); exp_decode("R3 decode rtype", 0);
    tick();
    opcode = 6'h23;
    expect_out("R7 rtype execute", 6, 2, 1, 0, 0, 0, 0, 0);
    tick(); expect_out("R11 rtype write-back despite opcode change", 7, 0, 0, 0, 2, 0, 0, 0);
    tick(); exp_fetch("R7 rtype returns to fetch");
  endtask

  task automatic t_branch();
    opcode = 6'h04;
    tick(); exp_decode("R3 decode branch", 0);
    tick(); expect_out("R8 branch compare", 8, 1, 1, 0, 0, 0, 2, 0);
    tick(); exp_fetch("R8 branch returns to fetch");
  endtask

  task automatic t_jump();
    opcode = 6'h3F;
    #1;
    exp_fetch("R11 fetch ignores opcode");
    opcode = 6'h02;
    tick(); exp_decode("R3 decode jump", 0);
    tick(); expect_out("R9 jump", 9, 0, 0, 0, 0, 0, 3, 0);
    tick(); exp_fetch("R9 jump returns to fetch");
  endtask

  task automatic t_illegal1();
    opcode = 6'h3F;
    tick(); exp_decode("R10 table 1 miss flag", 1);
    tick(); exp_fetch("R10 table 1 miss returns to fetch");
    tick(); exp_decode("R10 flag after miss", 1);
    opcode = 6'h04;
    #1;
    exp_decode("R10 flag clears on valid opcode", 0);
    tick(); expect_out("R3 branch after miss", 8, 1, 1, 0, 0, 0, 2, 0);
    tick(); exp_fetch("R8 back to fetch");
  endtask

  task automatic t_illegal2();
    opcode = 6'h2B;
    tick(); exp_decode("R3 decode before table 2 miss", 0);
    tick();
    opcode = 6'h04;
    #1;
    exp_maddr("R10 table 2 miss flag", 1);
    tick(); exp_fetch("R10 table 2 miss returns to fetch");
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_store();
    t_rtype();
    t_branch();
    t_jump();
    t_illegal1();
    t_illegal2();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule